// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits between a memory's write-cycle qualifier and its page-load logic. Every accepted write cycle, given as an address and a data byte, passes through it. It decides whether the write is forwarded as page data, consumed as one step of a command handshake, or rejected.

The block keeps a protection flag that models a non-volatile setting. Only the power-on reset clears this flag. The functional reset leaves it unchanged.

Two command handshakes are recognised:

- **Arm handshake (three steps).** It opens a one-shot load window. When the page loader reports that programming is done, the protection flag is set.
- **Release handshake (six steps).** After a write-cycle delay, it clears the protection flag.

While the flag is set, a write that does not come through an opened window is rejected, and a one-cycle rejection pulse is raised. Bus timing, the array and the page buffer lie outside this block.

Top module: `wp_cmd_seq`

## Requirements
- R1: After power-on reset `prot_flag` is 0. While unprotected, a write that is not a command step produces a one-cycle `wr_permit` pulse in the cycle after the write.
- R2: A write that matches the expected next command step is consumed. It raises neither `wr_permit` nor `wr_blocked`.
- R3: The arm handshake is three writes in this order: data 0xAA at address 0x5555, data 0x55 at 0x2AAA, data 0xA0 at 0x5555. The cycle after the third write, `win_start` pulses high for exactly one cycle.
- R4: While the window is open, each write is page data, whatever the protection state. The first PAGE_BYTES writes give `wr_permit`. Any further write gives `wr_blocked` until the window closes.
- R5: `prog_done` while the window is open closes the window and sets `prot_flag` in the following cycle. `prog_done` with no window open has no effect.
- R6: While protected and outside a window, a write that is not a command step gives a one-cycle `wr_blocked` pulse and no `wr_permit`. The two pulses are never high together.
- R7: Only address bits 14..0 are compared against command addresses. Bits 16 and 15 may hold any value.
- R8: A write that does not match the expected step returns the matcher to idle. If that write is data 0xAA at 0x5555, it counts as the first step of a new handshake.
- R9: The functional reset `rst_n` clears the matcher, the window and the release delay. It does not clear `prot_flag`.
- R10: The release handshake is six writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. `prot_flag` falls TWC_CYCLES clock edges after the edge that took the sixth write.
- R11: During the release delay, every write is rejected with `wr_blocked` and is not matched.
- R12: `por_n` low clears `prot_flag` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | Functional reset, synchronous, active low; keeps the protection flag |
| wr_valid | input | 1 | One accepted write cycle this clock |
| wr_addr | input | ADDR_W (17) | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | Page programming has finished |
| wr_permit | output | 1 | Pulse: forward this write to the page loader |
| wr_blocked | output | 1 | Pulse: this write was rejected |
| win_start | output | 1 | Pulse: a command-opened load window began |
| prot_flag | output | 1 | Protection state |

## Verification
`wr_permit`, `wr_blocked` and `win_start` are registered, so each is due in the cycle after the edge that takes the write. The bench drives each write on a falling edge and samples the pulses on the next falling edge. A change of `prot_flag` caused by `prog_done` is also due one edge later. The release delay ends exactly TWC_CYCLES edges after the final handshake write. The bench counts falling edges from that write and samples once just before the deadline, where the flag must still be 1, and once at the deadline, where it must be 0.

// File: rtl/wp_pkg.sv
// Shared constants and types for the write-protection command sequencer.
// Assumes command addresses are compared on 15 low address bits.
package wp_pkg;
    localparam int CMP_W  = 15;
    localparam int DATA_W = 8;

    localparam logic [CMP_W-1:0]  CMD_ADR_P = 15'h5555;
    localparam logic [CMP_W-1:0]  CMD_ADR_Q = 15'h2AAA;
    localparam logic [DATA_W-1:0] CODE_LEAD = 8'hAA;
    localparam logic [DATA_W-1:0] CODE_KEY  = 8'h55;
    localparam logic [DATA_W-1:0] CODE_ARM  = 8'hA0;
    localparam logic [DATA_W-1:0] CODE_EXT  = 8'h80;
    localparam logic [DATA_W-1:0] CODE_REL  = 8'h20;

    // Matcher progress: number of handshake steps seen so far.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_G1   = 3'd1,
        ST_G2   = 3'd2,
        ST_D3   = 3'd3,
        ST_D4   = 3'd4,
        ST_D5   = 3'd5
    } step_t;
endpackage

// File: rtl/wp_cmd_match.sv
// Command handshake matcher. It tracks the arm and release handshakes
// step by step. A step that does not match returns it to idle, and a
// lead step (0xAA at 0x5555) restarts it. It assumes valid_i is only
// high when the controller lets the matcher see the write.
module wp_cmd_match
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CMP_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              absorb_o,
    output logic              arm_hit_o,
    output logic              rel_hit_o
);
    step_t step_q, step_d;
    logic  at_p, at_q, is_lead;

    assign at_p    = (addr_i == CMD_ADR_P);
    assign at_q    = (addr_i == CMD_ADR_Q);
    assign is_lead = at_p && (data_i == CODE_LEAD);

    // Next step and hit decode for the current write.
    always_comb begin
        step_d    = step_q;
        absorb_o  = 1'b0;
        arm_hit_o = 1'b0;
        rel_hit_o = 1'b0;
        if (valid_i) begin
            case (step_q)
                ST_IDLE: if (is_lead) begin
                    step_d = ST_G1; absorb_o = 1'b1;
                end
                ST_G1: if (at_q && data_i == CODE_KEY) begin
                    step_d = ST_G2; absorb_o = 1'b1;
                end
                ST_G2: if (at_p && data_i == CODE_ARM) begin
                    step_d = ST_IDLE; absorb_o = 1'b1; arm_hit_o = 1'b1;
                end else if (at_p && data_i == CODE_EXT) begin
                    step_d = ST_D3; absorb_o = 1'b1;
                end
                ST_D3: if (is_lead) begin
                    step_d = ST_D4; absorb_o = 1'b1;
                end
                ST_D4: if (at_q && data_i == CODE_KEY) begin
                    step_d = ST_D5; absorb_o = 1'b1;
                end
                ST_D5: if (at_p && data_i == CODE_REL) begin
                    step_d = ST_IDLE; absorb_o = 1'b1; rel_hit_o = 1'b1;
                end
                default: step_d = ST_IDLE;
            endcase
            if (!absorb_o) begin
                if (is_lead) begin
                    step_d   = ST_G1;
                    absorb_o = 1'b1;
                end else begin
                    step_d = ST_IDLE;
                end
            end
        end
    end

    // Step register; either reset returns to idle.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) step_q <= ST_IDLE;
        else                  step_q <= step_d;
    end

    // R8: a hit always completes the handshake, so the matcher is idle afterwards.
    a_r8_idle_after_hit: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (arm_hit_o || rel_hit_o) |=> (step_q == ST_IDLE));
endmodule

// File: rtl/wp_mode_ctl.sv
// Mode control: the persistent protection flag, the command-opened load
// window with its byte count, and the release delay timer. It assumes
// prog_done_i is a one-cycle report from the page loader.
module wp_mode_ctl #(
    parameter int PAGE_BYTES = 256,
    parameter int TWC_CYCLES = 50
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wr_valid_i,
    input  logic prog_done_i,
    input  logic arm_hit_i,
    input  logic rel_hit_i,
    output logic prot_o,
    output logic win_o,
    output logic full_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam int TMR_W = (TWC_CYCLES > 2) ? $clog2(TWC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PAGE_BYTES);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TWC_CYCLES - 1);

    logic             prot_q, win_q, busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_end;

    assign full_o  = (cnt_q == CNT_MAX);
    assign tmr_end = busy_q && (tmr_q == TMR_LAST);

    // Protection flag: cleared only by power-on reset; held by functional reset.
    always_ff @(posedge clk) begin
        if (!por_n)               prot_q <= 1'b0;
        else if (rst_n) begin
            if (win_q && prog_done_i) prot_q <= 1'b1;
            else if (tmr_end)         prot_q <= 1'b0;
        end
    end

    // Load window and its byte count.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            win_q <= 1'b0;
            cnt_q <= '0;
        end else if (arm_hit_i) begin
            win_q <= 1'b1;
            cnt_q <= '0;
        end else if (win_q && prog_done_i) begin
            win_q <= 1'b0;
        end else if (win_q && wr_valid_i && !full_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Release delay timer started by the final release step.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
        end else if (rel_hit_i) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
        end else if (tmr_end) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign prot_o = prot_q;
    assign win_o  = win_q;
    assign busy_o = busy_q;

    // R12: power-on reset clears protection.
    a_r12_por_clears: assert property (@(posedge clk) !por_n |=> !prot_q);
    // R9: a functional reset alone leaves protection untouched.
    a_r9_func_rst_keeps: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (prot_q == $past(prot_q)));
    // R5: protection rises only when programming ends inside a window.
    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!por_n)
        $rose(prot_q) |-> $past(win_q && prog_done_i));
    // R10: protection falls only after the release delay or by power-on reset.
    a_r10_fall_cause: assert property (@(posedge clk)
        $fell(prot_q) |-> $past(busy_q || !por_n));
    // R4: the byte count never passes the page size.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/wp_write_gate.sv
// Write gate: classifies each write as forwarded, consumed or rejected,
// and registers the one-cycle result pulses. It assumes that the mode
// inputs describe the state before the write is applied.
module wp_write_gate (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wr_valid_i,
    input  logic busy_i,
    input  logic win_i,
    input  logic full_i,
    input  logic absorb_i,
    input  logic prot_i,
    input  logic arm_hit_i,
    output logic permit_o,
    output logic blocked_o,
    output logic win_start_o
);
    logic permit_d, blocked_d;
    logic permit_q, blocked_q, start_q;

    // Decide the fate of the current write.
    always_comb begin
        permit_d  = 1'b0;
        blocked_d = 1'b0;
        if (wr_valid_i) begin
            if (busy_i)        blocked_d = 1'b1;
            else if (win_i)    begin permit_d = !full_i; blocked_d = full_i; end
            else if (absorb_i) permit_d = 1'b0;
            else if (prot_i)   blocked_d = 1'b1;
            else               permit_d = 1'b1;
        end
    end

    // Register the result pulses.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            permit_q  <= 1'b0;
            blocked_q <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            permit_q  <= permit_d;
            blocked_q <= blocked_d;
            start_q   <= arm_hit_i;
        end
    end

    assign permit_o    = permit_q;
    assign blocked_o   = blocked_q;
    assign win_start_o = start_q;

    // R6: a write is never both forwarded and rejected.
    a_r6_permit_block_excl: assert property (@(posedge clk) disable iff (!por_n)
        !(permit_q && blocked_q));
    // R11: nothing is forwarded for a write taken during the release delay.
    a_r11_busy_no_permit: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        busy_i |=> !permit_q);
    // R3: the window-start pulse lasts one cycle.
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        start_q |=> !start_q);
endmodule

// File: rtl/wp_cmd_seq.sv
// Top of the write-protection command sequencer. It joins the handshake
// matcher, the mode control and the write gate. It assumes one qualified
// write event per wr_valid cycle.
module wp_cmd_seq
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_BYTES = 256,
    parameter int TWC_CYCLES = 50
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              wr_permit,
    output logic              wr_blocked,
    output logic              win_start,
    output logic              prot_flag
);
    logic absorb, arm_hit, rel_hit;
    logic prot, win, full, busy;
    logic match_valid;
    logic addr_hi_unused;

    // Upper address bits take no part in command matching.
    assign addr_hi_unused = ^wr_addr[ADDR_W-1:CMP_W];
    // The matcher sees only writes outside a window and the release delay.
    assign match_valid = wr_valid && !busy && !win;

    wp_cmd_match u_match (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .valid_i   (match_valid),
        .addr_i    (wr_addr[CMP_W-1:0]),
        .data_i    (wr_data),
        .absorb_o  (absorb),
        .arm_hit_o (arm_hit),
        .rel_hit_o (rel_hit)
    );

    wp_mode_ctl #(
        .PAGE_BYTES (PAGE_BYTES),
        .TWC_CYCLES (TWC_CYCLES)
    ) u_mode (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_valid_i  (wr_valid),
        .prog_done_i (prog_done),
        .arm_hit_i   (arm_hit),
        .rel_hit_i   (rel_hit),
        .prot_o      (prot),
        .win_o       (win),
        .full_o      (full),
        .busy_o      (busy)
    );

    wp_write_gate u_gate (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_valid_i  (wr_valid),
        .busy_i      (busy),
        .win_i       (win),
        .full_i      (full),
        .absorb_i    (absorb),
        .prot_i      (prot),
        .arm_hit_i   (arm_hit),
        .permit_o    (wr_permit),
        .blocked_o   (wr_blocked),
        .win_start_o (win_start)
    );

    assign prot_flag = prot;
endmodule

// File: tb/wp_cmd_seq_tb_top.sv
// Directed bench for the write-protection command sequencer.
module wp_cmd_seq_tb_top;
    localparam int PB = 4;
    localparam int TW = 20;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic        wr_permit, wr_blocked, win_start, prot_flag;
    logic        s_perm, s_blk, s_win;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    wp_cmd_seq #(.ADDR_W(17), .PAGE_BYTES(PB), .TWC_CYCLES(TW)) dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
        .wr_permit(wr_permit), .wr_blocked(wr_blocked),
        .win_start(win_start), .prot_flag(prot_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write; results of that write are sampled one edge later.
    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        s_perm = wr_permit; s_blk = wr_blocked; s_win = win_start;
        wr_valid = 1'b0;
    endtask

    task automatic pulse_done();
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic arm(input logic [16:0] hi);
        wr(hi | 17'h05555, 8'hAA);
        check("R2 step1 permit", {7'd0, s_perm}, 8'd0);
        check("R2 step1 blocked", {7'd0, s_blk}, 8'd0);
        wr(hi | 17'h02AAA, 8'h55);
        check("R2 step2 consumed", {6'd0, s_perm, s_blk}, 8'd0);
        wr(hi | 17'h05555, 8'hA0);
        check("R3 window start", {7'd0, s_win}, 8'd1);
        check("R3 step3 no permit", {7'd0, s_perm}, 8'd0);
        @(negedge clk);
        check("R3 start one cycle", {7'd0, win_start}, 8'd0);
    endtask

    task automatic t_reset_and_plain();
        check("R1 reset prot", {7'd0, prot_flag}, 8'd0);
        check("R1 reset pulses", {5'd0, wr_permit, wr_blocked, win_start}, 8'd0);
        wr(17'h00123, 8'h3C);
        check("R1 plain permit", {7'd0, s_perm}, 8'd1);
        @(negedge clk);
        check("R1 permit one cycle", {7'd0, wr_permit}, 8'd0);
        pulse_done();
        check("R5 done without window ignored", {7'd0, prot_flag}, 8'd0);
    endtask

    task automatic t_arm_page_limit();
        arm(17'h00000);
        for (int i = 0; i < PB; i++) begin
            wr(17'h00200 + 17'(i), 8'(i));
            check("R4 window byte permitted", {7'd0, s_perm}, 8'd1);
        end
        wr(17'h00210, 8'h77);
        check("R4 over page blocked", {6'd0, s_perm, s_blk}, 8'd1);
        check("R5 still unprotected", {7'd0, prot_flag}, 8'd0);
        pulse_done();
        check("R5 protected after done", {7'd0, prot_flag}, 8'd1);
    endtask

    task automatic t_protected_block();
        wr(17'h00040, 8'h99);
        check("R6 protected write blocked", {6'd0, s_perm, s_blk}, 8'd1);
        @(negedge clk);
        check("R6 blocked one cycle", {7'd0, wr_blocked}, 8'd0);
    endtask

    task automatic t_high_bits();
        arm(17'h18000);
        wr(17'h00300, 8'h11);
        check("R7 window byte while protected", {6'd0, s_perm, s_blk}, 8'd2);
        pulse_done();
        check("R7 protected again", {7'd0, prot_flag}, 8'd1);
    endtask

    task automatic t_break_restart();
        wr(17'h05555, 8'hAA);
        wr(17'h01234, 8'h11);
        check("R8 breaking write blocked", {6'd0, s_perm, s_blk}, 8'd1);
        wr(17'h05555, 8'hAA);
        wr(17'h05555, 8'hAA);
        check("R8 restart consumed", {6'd0, s_perm, s_blk}, 8'd0);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0);
        check("R8 restarted handshake opens", {7'd0, s_win}, 8'd1);
        pulse_done();
    endtask

    task automatic t_func_reset();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 prot kept over functional reset", {7'd0, prot_flag}, 8'd1);
        wr(17'h05555, 8'hA0);
        check("R9 matcher cleared", {6'd0, s_win, s_blk}, 8'd1);
    endtask

    task automatic t_release();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'h20);
        check("R2 release step consumed", {6'd0, s_perm, s_blk}, 8'd0);
        wr(17'h00050, 8'h42);
        check("R11 write in delay blocked", {6'd0, s_perm, s_blk}, 8'd1);
        repeat (TW - 2) @(negedge clk);
        check("R10 prot held before delay end", {7'd0, prot_flag}, 8'd1);
        @(negedge clk);
        check("R10 prot cleared at delay end", {7'd0, prot_flag}, 8'd0);
        wr(17'h00051, 8'h43);
        check("R1 plain permit after release", {7'd0, s_perm}, 8'd1);
    endtask

    task automatic t_por();
        arm(17'h00000);
        pulse_done();
        check("R12 protected before por", {7'd0, prot_flag}, 8'd1);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        check("R12 por clears prot", {7'd0, prot_flag}, 8'd0);
        wr(17'h00060, 8'h01);
        check("R12 plain permit after por", {7'd0, s_perm}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_plain();
        t_arm_page_limit();
        t_protected_block();
        t_high_bits();
        t_break_restart();
        t_func_reset();
        t_release();
        t_por();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule